// File: doc/BRIEF.md
# I2S Master Audio Transmitter

This block plays stereo PCM audio out to a codec as the I2S bus master. A producer offers left and right samples over a valid/ready handshake. The block drives the bit clock, the word select and the serial data line. It never receives serial data and never runs as a bus slave. All logic runs on one core clock. The bus clocks are registered outputs that the core clock steps.

The master clock (MCLK) can come from two places, chosen by a configuration input. In the first case the block makes MCLK by dividing the core clock and drives it out on the MCLK pin. In the second case the pin is left undriven and an external MCLK is synchronised and used as the timebase. A 2-bit rate select picks one of three sample rates: 32 kHz, 44.1 kHz and 48 kHz. Each rate has its own core-clock divider, and this divider stands in for a PLL. The bit clock is MCLK/4, so one frame is 64 bit clocks (256 MCLK periods), with 32 bit slots per channel.

Word select is low for the left channel and high for the right channel. It changes one bit clock before the MSB of each channel word. Data is sent MSB first and changes on the falling bit-clock edge, so the codec samples it on the rising edge. A new sample pair is taken only at the frame boundary. If none is offered there, the block sends a silent frame and sets a sticky underrun flag.

Top module: `i2s_tx_master`

## Requirements
- R1: While reset is held and just after it is released, bclk, ws, sd, underrun, s_ready and mclk_out are low, and mclk_oe is high when cfg_mclk_ext is low.
- R2: With cfg_mclk_ext low, mclk_oe is high and mclk_out is the internally divided MCLK. With cfg_mclk_ext high, mclk_oe and mclk_out are low, and the rising edges of mclk_in set the timing.
- R3: In internal mode, each MCLK half period lasts HALF_32K core cycles for rate_sel 0, HALF_44K for rate_sel 1, and HALF_48K for rate_sel 2 and 3.
- R4: bclk stays high for two MCLK periods and low for two MCLK periods. A frame has 64 bclk periods.
- R5: Bit slots are numbered 0 to 63 within a frame, and each slot starts at a falling bclk edge. ws is low in slots 0 to 31 and high in slots 32 to 63. It changes only at falling bclk edges.
- R6: sd changes only at falling bclk edges. The left sample sits in slots 1 to 32 and the right sample in slots 33 to 63 plus slot 0 of the next frame. Each sample is MSB first, with SAMPLE_W bits followed by zero fill up to 32 bits.
- R7: s_ready is high for exactly one core cycle per frame: the cycle just before bclk falls into slot 0. The sample pair on s_left and s_right is taken when s_valid is high in that cycle.
- R8: If s_valid is low in the s_ready cycle, that frame carries all zeros. underrun then goes high and stays high until reset.
- R9: A change of rate_sel or cfg_mclk_ext during operation changes only the bit timing. The serial bit stream goes on with no lost or repeated bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mclk_ext | input | 1 | 1: take MCLK from mclk_in; 0: generate and drive MCLK |
| rate_sel | input | 2 | 0: 32 kHz, 1: 44.1 kHz, 2 and 3: 48 kHz |
| mclk_in | input | 1 | External master clock (used when cfg_mclk_ext is 1) |
| mclk_out | output | 1 | Generated master clock |
| mclk_oe | output | 1 | Output enable for the MCLK pin |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Sample pair taken this cycle (frame boundary) |
| s_left | input | SAMPLE_W | Left-channel sample |
| s_right | input | SAMPLE_W | Right-channel sample |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word select (0 left, 1 right) |
| sd | output | 1 | Serial data |
| underrun | output | 1 | Sticky: a frame went out with no sample pair |

## Verification
The assertions assume that mclk_in, when it is used, stays at each level for at least two core cycles. Under that assumption every synchronised rising edge is seen exactly once, and each bclk level lasts several core cycles. They also assume that the producer only expects a transfer in the single s_ready cycle. The stimulus drives mclk_in with a period of eight core cycles. It changes samples, s_valid and configuration only just after a rising core-clock edge, and never inside a ready cycle.

// File: rtl/i2s_tx_master.sv
module i2s_tx_master #(
  parameter int SAMPLE_W = 24,
  parameter int HALF_32K = 6,
  parameter int HALF_44K = 5,
  parameter int HALF_48K = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_mclk_ext,
  input  logic [1:0]          rate_sel,
  input  logic                mclk_in,
  output logic                mclk_out,
  output logic                mclk_oe,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  output logic                bclk,
  output logic                ws,
  output logic                sd,
  output logic                underrun
);

  localparam int HMAX  = (HALF_32K > HALF_44K) ?
                         ((HALF_32K > HALF_48K) ? HALF_32K : HALF_48K) :
                         ((HALF_44K > HALF_48K) ? HALF_44K : HALF_48K);
  localparam int CW    = $clog2(HMAX + 1);
  localparam int SLOTW = 32;
  localparam int PAD   = SLOTW - SAMPLE_W;

  logic [CW-1:0] half_len;
  logic [CW-1:0] hc;
  logic          mclk_int;
  logic [2:0]    msync;
  logic          half_end;
  logic          tick;
  logic          phase;
  logic          bclk_q;
  logic [5:0]    slot;
  logic [5:0]    slot_nxt;
  logic [63:0]   shreg;
  logic [63:0]   frame;
  logic          ws_q;
  logic          sd_q;
  logic          ur_q;
  logic          fall_evt;
  logic          load;

  always_comb begin
    case (rate_sel)
      2'd0:    half_len = CW'(HALF_32K);
      2'd1:    half_len = CW'(HALF_44K);
      default: half_len = CW'(HALF_48K);
    endcase
  end

  assign half_end = (hc >= half_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc       <= '0;
      mclk_int <= 1'b0;
    end else if (half_end) begin
      hc       <= '0;
      mclk_int <= ~mclk_int;
    end else begin
      hc       <= hc + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) msync <= '0;
    else        msync <= {msync[1:0], mclk_in};
  end

  assign tick     = cfg_mclk_ext ? (msync[1] & ~msync[2]) : (half_end & ~mclk_int);
  assign fall_evt = tick & phase & bclk_q;
  assign load     = fall_evt & (slot == 6'd63);
  assign slot_nxt = slot + 6'd1;

  assign frame = s_valid ? {32'(s_left) << PAD, 32'(s_right) << PAD} : 64'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= 1'b0;
      bclk_q <= 1'b0;
    end else if (tick) begin
      phase <= ~phase;
      if (phase) bclk_q <= ~bclk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot  <= 6'd63;
      shreg <= '0;
      ws_q  <= 1'b0;
      sd_q  <= 1'b0;
      ur_q  <= 1'b0;
    end else if (fall_evt) begin
      slot <= slot_nxt;
      ws_q <= slot_nxt[5];
      sd_q <= shreg[63];
      if (load) begin
        shreg <= frame;
        ur_q  <= ur_q | ~s_valid;
      end else begin
        shreg <= shreg << 1;
      end
    end
  end

  assign mclk_out = mclk_int & ~cfg_mclk_ext;
  assign mclk_oe  = ~cfg_mclk_ext;
  assign s_ready  = load;
  assign bclk     = bclk_q;
  assign ws       = ws_q;
  assign sd       = sd_q;
  assign underrun = ur_q;

endmodule

module i2s_tx_master_chk (
  input logic clk,
  input logic rst_n,
  input logic s_valid,
  input logic s_ready,
  input logic bclk,
  input logic ws,
  input logic sd,
  input logic underrun
);

  a_r7_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !s_ready);

  a_r7_ready_before_fall: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> $fell(bclk));

  a_r5_ws_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws) |-> $fell(bclk));

  a_r6_sd_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd) |-> $fell(bclk));

  a_r8_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  a_r8_underrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(s_ready && !s_valid));

endmodule

bind i2s_tx_master i2s_tx_master_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .bclk     (bclk),
  .ws       (ws),
  .sd       (sd),
  .underrun (underrun)
);

// File: tb/i2s_tx_master_bench.sv
`timescale 1ns/1ps
module i2s_tx_master_bench;
  localparam int W   = 24;
  localparam int H32 = 6;
  localparam int H44 = 5;
  localparam int H48 = 4;
  localparam int EXT_HALF = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic cfg_mclk_ext = 0;
  logic [1:0] rate_sel = 0;
  logic mclk_in = 0;
  logic mclk_out, mclk_oe, s_ready, bclk, ws, sd, underrun;
  logic s_valid = 0;
  logic [W-1:0] s_left = 0, s_right = 0;

  i2s_tx_master #(.SAMPLE_W(W), .HALF_32K(H32), .HALF_44K(H44), .HALF_48K(H48)) u_i2s_tx_master (
    .clk(clk), .rst_n(rst_n), .cfg_mclk_ext(cfg_mclk_ext), .rate_sel(rate_sel),
    .mclk_in(mclk_in), .mclk_out(mclk_out), .mclk_oe(mclk_oe),
    .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
    .bclk(bclk), .ws(ws), .sd(sd), .underrun(underrun));

  always #5 clk = ~clk;

  int vectors = 0, fails = 0;
  int settle = 0, frames_done = 0, exp_bhi = 4*H32, exp_mhi = H32;
  bit mon_on = 0, exp_ur = 0, done = 0;
  logic [63:0] q[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  function automatic logic [63:0] fw(input logic [W-1:0] l, input logic [W-1:0] r);
    return {32'(l) << (32-W), 32'(r) << (32-W)};
  endfunction

  function automatic int half_of(input logic [1:0] rs);
    return (rs == 2'd0) ? H32 : (rs == 2'd1) ? H44 : H48;
  endfunction

  task automatic set_cfg(input bit ext, input logic [1:0] rs);
    @(posedge clk); #1;
    cfg_mclk_ext = ext;
    rate_sel = rs;
    exp_mhi = half_of(rs);
    exp_bhi = ext ? 4*EXT_HALF : 4*half_of(rs);
    settle = 0;
  endtask

  task automatic set_src(input int n);
    case (n)
      0: begin s_valid = 1; s_left = '1; s_right = '0; end
      1: begin s_valid = 1; s_left = '0; s_right = '1; end
      2: begin s_valid = 1; s_left = W'(1); s_right = W'(1) << (W-1); end
      3, 4: begin s_valid = 0; s_left = W'($urandom); s_right = W'($urandom); end
      default: begin
        s_valid = ($urandom % 8) != 0;
        s_left = W'($urandom);
        s_right = W'($urandom);
      end
    endcase
  endtask

  initial begin
    forever begin
      repeat (EXT_HALF) @(posedge clk);
      #1 mclk_in = ~mclk_in;
    end
  end

  // source driver: a pair is taken in the s_ready cycle
  initial begin
    int n;
    n = 0;
    void'($urandom(32'd20240611));
    set_src(0);
    wait (mon_on);
    forever begin
      @(negedge clk);
      if (s_ready) begin
        if (s_valid) q.push_back(fw(s_left, s_right));
        else begin q.push_back(64'd0); exp_ur = 1; end
        n++;
        @(posedge clk); #1;
        set_src(n);
      end
    end
  end

  // port-level receiver and timing monitor
  initial begin
    bit pb, pws, pm, pready, seen_fall, rdy_seen;
    int hi, mhi, pos;
    logic [63:0] acc, e;
    pb = 0; pws = 0; pm = 0; pready = 0; seen_fall = 0; rdy_seen = 0;
    hi = 0; mhi = 0; pos = 0; acc = '0;
    wait (mon_on);
    forever begin
      @(negedge clk);
      if (rdy_seen) chk(bclk == 1'b0, "R7 bclk falls after ready", 64'(bclk), 0);
      rdy_seen = 0;
      if (bclk) hi++;
      if (pb && !bclk) begin
        if (settle >= 3) begin
          chk(hi == exp_bhi, "R4 bclk high time", 64'(hi), 64'(exp_bhi));
          if (cfg_mclk_ext)
            chk(!mclk_out && !mclk_oe, "R2 external source pins", {mclk_out, mclk_oe}, 0);
          else
            chk(mclk_oe, "R2 internal source enable", 64'(mclk_oe), 1);
        end
        hi = 0;
        settle++;
      end
      if (!pb && bclk) begin
        acc = {acc[62:0], sd};
        pos++;
        if (pws && !ws) begin
          if (seen_fall) chk(pos == 64, "R4 bits per frame", 64'(pos), 64);
          if (q.size() == 0) chk(0, "R6 frame with no load", acc, 0);
          else begin
            e = q.pop_front();
            chk(acc == e, "R6 R9 frame data", acc, e);
          end
          chk(underrun == exp_ur, "R8 underrun flag", 64'(underrun), 64'(exp_ur));
          frames_done++;
          seen_fall = 1;
          pos = 0;
        end else if (!pws && ws && seen_fall) begin
          chk(pos == 32, "R5 ws rise slot", 64'(pos), 32);
        end
        pws = ws;
      end
      pb = bclk;
      if (!cfg_mclk_ext) begin
        if (mclk_out) mhi++;
        if (pm && !mclk_out) begin
          if (settle >= 3) chk(mhi == exp_mhi, "R3 mclk half period", 64'(mhi), 64'(exp_mhi));
          mhi = 0;
        end
      end
      pm = mclk_out;
      if (s_ready) begin
        chk(!pready, "R7 ready single cycle", 64'(pready), 0);
        chk(bclk == 1'b1, "R7 ready at slot end", 64'(bclk), 1);
        rdy_seen = 1;
      end
      pready = s_ready;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk({bclk, ws, sd, underrun, s_ready, mclk_out} == 6'b0, "R1 in reset", {bclk, ws, sd, underrun, s_ready, mclk_out}, 0);
    chk(mclk_oe == 1'b1, "R1 oe in reset", 64'(mclk_oe), 1);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk({bclk, ws, sd, underrun, s_ready, mclk_out} == 6'b0, "R1 after release", {bclk, ws, sd, underrun, s_ready, mclk_out}, 0);
    mon_on = 1;
    wait (frames_done >= 7);
    set_cfg(0, 2'd1);
    wait (frames_done >= 13);
    set_cfg(0, 2'd3);
    wait (frames_done >= 19);
    set_cfg(0, 2'd2);
    wait (frames_done >= 25);
    set_cfg(1, 2'd0);
    wait (frames_done >= 33);
    chk(exp_ur == 1'b1, "R8 underrun exercised", 64'(exp_ur), 1);
    done = 1;
    summary();
  end
endmodule